// File: doc/BRIEF.md
# Multi-cycle pipeline stall controller

This block produces the freeze controls for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) in which two stages can take more than one cycle. A data-memory access keeps the memory stage occupied for 10 advance ticks. A multi-cycle register-register operation keeps the execute stage occupied for 5 advance ticks. Each unit has its own latency timer, loaded by a one-cycle start pulse and counted down by an advance tick. The timer's busy flag and remaining count are visible at the ports.

From the two busy flags the block picks one of three freeze modes. In FRZ_MEM the program counter and the fetch, decode, execute and memory pipeline registers all hold. In FRZ_EXE only the program counter and the fetch, decode and execute registers hold, so the memory and writeback stages keep draining. In FRZ_NONE nothing holds and every register takes its next value on the same edge. A busy memory unit outranks a busy execute unit.

Each timer is a two-state machine.
- UNIT_IDLE goes to UNIT_RUN on a start pulse, and the count is loaded with the latency on that same edge.
- UNIT_RUN decrements the count on every ticked cycle.
- UNIT_RUN returns to UNIT_IDLE on the ticked edge that takes the count from 1 to 0.
- A start pulse seen in UNIT_RUN is dropped.

The freeze mode is decoded from the busy flags alone:
- FRZ_MEM whenever the memory unit is busy.
- Otherwise FRZ_EXE if the execute unit is busy.
- Otherwise FRZ_NONE.

Top module: `stall_ctrl`

## Requirements
- R1: After synchronous reset, both busy flags are 0, both counts are 0 and every hold output is 0.
- R2: A memory start pulse while the memory unit is idle makes the memory unit busy with a count of 10 on the next cycle.
- R3: An execute start pulse while the execute unit is idle makes the execute unit busy with a count of 5 on the next cycle.
- R4: While a unit is busy, a cycle with the advance tick at 1 lowers its count by one, and a cycle with the tick at 0 leaves the count unchanged.
- R5: A unit's busy flag clears on the same edge at which its count reaches 0. Busy is therefore 1 exactly when the count is nonzero, and the freeze is released in that same cycle.
- R6: A start pulse for a unit that is already busy is ignored: the count is not reloaded and it continues its countdown.
- R7: While the memory unit is busy, hold_pc, hold_fetch, hold_decode, hold_exec and hold_mem are all 1.
- R8: While only the execute unit is busy, hold_pc, hold_fetch, hold_decode and hold_exec are 1 and hold_mem is 0.
- R9: When both units are busy, the holds follow the memory pattern of R7.
- R10: When neither unit is busy, all five hold outputs are 0.
- R11: A synchronous reset during an operation clears both counts and both busy flags on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_start | input | 1 | Start pulse for a data-memory access |
| exe_start | input | 1 | Start pulse for a multi-cycle execute operation |
| adv_tick | input | 1 | Advance tick; busy counters decrement on cycles where it is 1 |
| hold_pc | output | 1 | Program counter keeps its value |
| hold_fetch | output | 1 | Fetch pipeline register keeps its value |
| hold_decode | output | 1 | Decode pipeline register keeps its value |
| hold_exec | output | 1 | Execute pipeline register keeps its value |
| hold_mem | output | 1 | Memory pipeline register keeps its value |
| mem_busy | output | 1 | Memory unit timer is running |
| exe_busy | output | 1 | Execute unit timer is running |
| mem_count | output | 4 | Remaining memory ticks (width from MEM_LAT) |
| exe_count | output | 3 | Remaining execute ticks (width from EXE_LAT) |

## Verification
The properties take it that reset is synchronous and that start and tick inputs are stable around the clock edge. They place no limit on when start pulses arrive, so pulses during a busy period, or on the very edge where a unit finishes, are legal stimulus and must be dropped. The bench drives inputs just after each sampling point, mixes random start and tick patterns, and adds occasional resets mid-operation. Directed sequences force overlapping memory and execute operations and stalled ticks, so that the priority and the hold-still cases occur.

// File: rtl/stall_pkg.sv
package stall_pkg;

    typedef enum logic {
        UNIT_IDLE = 1'b0,
        UNIT_RUN  = 1'b1
    } unit_state_t;

    typedef enum logic [1:0] {
        FRZ_NONE = 2'd0,
        FRZ_EXE  = 2'd1,
        FRZ_MEM  = 2'd2
    } freeze_t;

    typedef struct packed {
        logic pc;
        logic fe;
        logic de;
        logic ex;
        logic me;
    } hold_vec_t;

endpackage

// File: rtl/lat_timer.sv
module lat_timer
    import stall_pkg::*;
#(
    parameter int LAT = 10,
    parameter int W   = $clog2(LAT + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         tick,
    output logic         busy,
    output logic [W-1:0] count
);

    unit_state_t  state_q, state_n;
    logic [W-1:0] cnt_q, cnt_n;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= UNIT_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // next-state logic
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            UNIT_IDLE: begin
                if (start) begin
                    state_n = UNIT_RUN;
                    cnt_n   = W'(LAT);
                end
            end
            UNIT_RUN: begin
                // start is dropped while running
                if (tick) begin
                    cnt_n = cnt_q - 1'b1;
                    if (cnt_q == W'(1)) begin
                        state_n = UNIT_IDLE;
                    end
                end
            end
            default: begin
                state_n = UNIT_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        busy  = (state_q == UNIT_RUN);
        count = cnt_q;
    end

endmodule

// File: rtl/freeze_sel.sv
module freeze_sel
    import stall_pkg::*;
(
    input  logic      mem_busy,
    input  logic      exe_busy,
    output hold_vec_t holds
);

    freeze_t mode;

    // memory unit outranks execute unit
    always_comb begin
        if (mem_busy) begin
            mode = FRZ_MEM;
        end else if (exe_busy) begin
            mode = FRZ_EXE;
        end else begin
            mode = FRZ_NONE;
        end
    end

    always_comb begin
        holds = '0;
        unique case (mode)
            FRZ_MEM:  holds = '{pc: 1'b1, fe: 1'b1, de: 1'b1, ex: 1'b1, me: 1'b1};
            FRZ_EXE:  holds = '{pc: 1'b1, fe: 1'b1, de: 1'b1, ex: 1'b1, me: 1'b0};
            FRZ_NONE: holds = '0;
            default:  holds = '0;
        endcase
    end

endmodule

// File: rtl/stall_ctrl.sv
module stall_ctrl
    import stall_pkg::*;
#(
    parameter  int MEM_LAT = 10,
    parameter  int EXE_LAT = 5,
    localparam int MEM_W   = $clog2(MEM_LAT + 1),
    localparam int EXE_W   = $clog2(EXE_LAT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mem_start,
    input  logic             exe_start,
    input  logic             adv_tick,
    output logic             hold_pc,
    output logic             hold_fetch,
    output logic             hold_decode,
    output logic             hold_exec,
    output logic             hold_mem,
    output logic             mem_busy,
    output logic             exe_busy,
    output logic [MEM_W-1:0] mem_count,
    output logic [EXE_W-1:0] exe_count
);

    hold_vec_t holds;

    lat_timer #(.LAT(MEM_LAT), .W(MEM_W)) u_mem_timer (
        .clk   (clk),
        .rst   (rst),
        .start (mem_start),
        .tick  (adv_tick),
        .busy  (mem_busy),
        .count (mem_count)
    );

    lat_timer #(.LAT(EXE_LAT), .W(EXE_W)) u_exe_timer (
        .clk   (clk),
        .rst   (rst),
        .start (exe_start),
        .tick  (adv_tick),
        .busy  (exe_busy),
        .count (exe_count)
    );

    freeze_sel u_freeze (
        .mem_busy (mem_busy),
        .exe_busy (exe_busy),
        .holds    (holds)
    );

    assign hold_pc     = holds.pc;
    assign hold_fetch  = holds.fe;
    assign hold_decode = holds.de;
    assign hold_exec   = holds.ex;
    assign hold_mem    = holds.me;

endmodule

// File: rtl/stall_ctrl_chk.sv
module stall_ctrl_chk #(
    parameter  int MEM_LAT = 10,
    parameter  int EXE_LAT = 5,
    localparam int MEM_W   = $clog2(MEM_LAT + 1),
    localparam int EXE_W   = $clog2(EXE_LAT + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             mem_start,
    input logic             exe_start,
    input logic             adv_tick,
    input logic             hold_pc,
    input logic             hold_fetch,
    input logic             hold_decode,
    input logic             hold_exec,
    input logic             hold_mem,
    input logic             mem_busy,
    input logic             exe_busy,
    input logic [MEM_W-1:0] mem_count,
    input logic [EXE_W-1:0] exe_count
);

    p_reset_clear_r11: assert property (@(posedge clk)
        rst |=> (!mem_busy && !exe_busy && mem_count == '0 && exe_count == '0));

    p_mem_load_r2: assert property (@(posedge clk) disable iff (rst)
        (!mem_busy && mem_start) |=> (mem_busy && mem_count == MEM_W'(MEM_LAT)));

    p_exe_load_r3: assert property (@(posedge clk) disable iff (rst)
        (!exe_busy && exe_start) |=> (exe_busy && exe_count == EXE_W'(EXE_LAT)));

    p_mem_dec_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_busy && adv_tick) |=> (mem_count == $past(mem_count) - 1'b1));

    p_mem_still_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_busy && !adv_tick) |=> ($stable(mem_count) && mem_busy));

    p_exe_dec_r4: assert property (@(posedge clk) disable iff (rst)
        (exe_busy && adv_tick) |=> (exe_count == $past(exe_count) - 1'b1));

    p_mem_busy_cnt_r5: assert property (@(posedge clk) disable iff (rst)
        mem_busy == (mem_count != '0));

    p_exe_busy_cnt_r5: assert property (@(posedge clk) disable iff (rst)
        exe_busy == (exe_count != '0));

    p_mem_ignore_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_busy && mem_start && !adv_tick) |=> $stable(mem_count));

    p_exe_ignore_r6: assert property (@(posedge clk) disable iff (rst)
        (exe_busy && exe_start && !adv_tick) |=> $stable(exe_count));

    p_mem_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        mem_busy |-> (hold_pc && hold_fetch && hold_decode && hold_exec && hold_mem));

    p_exe_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        (exe_busy && !mem_busy) |->
            (hold_pc && hold_fetch && hold_decode && hold_exec && !hold_mem));

    p_both_freeze_r9: assert property (@(posedge clk) disable iff (rst)
        (exe_busy && mem_busy) |-> hold_mem);

    p_free_r10: assert property (@(posedge clk) disable iff (rst)
        (!exe_busy && !mem_busy) |->
            !(hold_pc || hold_fetch || hold_decode || hold_exec || hold_mem));

endmodule

bind stall_ctrl stall_ctrl_chk #(.MEM_LAT(MEM_LAT), .EXE_LAT(EXE_LAT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mem_start   (mem_start),
    .exe_start   (exe_start),
    .adv_tick    (adv_tick),
    .hold_pc     (hold_pc),
    .hold_fetch  (hold_fetch),
    .hold_decode (hold_decode),
    .hold_exec   (hold_exec),
    .hold_mem    (hold_mem),
    .mem_busy    (mem_busy),
    .exe_busy    (exe_busy),
    .mem_count   (mem_count),
    .exe_count   (exe_count)
);

// File: tb/tb_stall_ctrl.sv
module tb_stall_ctrl;

    localparam int MEM_LAT = 10;
    localparam int EXE_LAT = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mem_start = 1'b0;
    logic       exe_start = 1'b0;
    logic       adv_tick = 1'b0;
    logic       hold_pc, hold_fetch, hold_decode, hold_exec, hold_mem;
    logic       mem_busy, exe_busy;
    logic [3:0] mem_count;
    logic [2:0] exe_count;

    int n_checks = 0;
    int n_fail   = 0;
    int m_mem    = 0;
    int m_exe    = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    stall_ctrl dut (
        .clk(clk), .rst(rst), .mem_start(mem_start), .exe_start(exe_start),
        .adv_tick(adv_tick), .hold_pc(hold_pc), .hold_fetch(hold_fetch),
        .hold_decode(hold_decode), .hold_exec(hold_exec), .hold_mem(hold_mem),
        .mem_busy(mem_busy), .exe_busy(exe_busy),
        .mem_count(mem_count), .exe_count(exe_count)
    );

    function automatic int next_cnt(int cnt, bit start, bit tk, int lat);
        if (cnt == 0) return start ? lat : 0;
        if (tk) return cnt - 1;
        return cnt;
    endfunction

    function automatic int exp_holds(int mc, int ec);
        if (mc != 0) return 5'b11111;
        if (ec != 0) return 5'b11110;
        return 5'b00000;
    endfunction

    function automatic string load_tag(int cnt, bit start, bit tk, string ld);
        if (cnt == 0) return start ? ld : "R10";
        if (start) return "R6";
        if (cnt == 1 && tk) return "R5";
        return "R4";
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tm, string te);
        string th;
        int    hv;
        hv = int'({hold_pc, hold_fetch, hold_decode, hold_exec, hold_mem});
        if (m_mem != 0 && m_exe != 0) th = "R9";
        else if (m_mem != 0)          th = "R7";
        else if (m_exe != 0)          th = "R8";
        else                          th = "R10";
        chk(tm, "mem_count", int'(mem_count), m_mem);
        chk(tm, "mem_busy",  int'(mem_busy),  int'(m_mem != 0));
        chk(te, "exe_count", int'(exe_count), m_exe);
        chk(te, "exe_busy",  int'(exe_busy),  int'(m_exe != 0));
        chk(th, "holds",     hv,              exp_holds(m_mem, m_exe));
    endtask

    task automatic step(bit ms, bit es, bit tk, bit r);
        string tm, te;
        mem_start = ms;
        exe_start = es;
        adv_tick  = tk;
        rst       = r;
        @(posedge clk);
        if (r) begin
            tm = "R11"; te = "R11";
            m_mem = 0;  m_exe = 0;
        end else begin
            tm = load_tag(m_mem, ms, tk, "R2");
            te = load_tag(m_exe, es, tk, "R3");
            m_mem = next_cnt(m_mem, ms, tk, MEM_LAT);
            m_exe = next_cnt(m_exe, es, tk, EXE_LAT);
        end
        #1;
        check_all(tm, te);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (2) @(posedge clk);
        #1;
        check_all("R1", "R1");
        // directed: memory load, ignored restart, stalled ticks
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        step(0, 0, 1, 0);
        step(1, 0, 1, 0);
        // execute overlapping memory: priority
        step(0, 1, 1, 0);
        for (int i = 0; i < 12; i++) step(0, 0, 1, 0);
        // execute alone, with restart attempt and stall
        step(0, 1, 1, 0);
        step(0, 1, 0, 0);
        for (int i = 0; i < 6; i++) step(0, 0, 1, 0);
        // restart on finishing edge of memory
        step(1, 0, 1, 0);
        for (int i = 0; i < 9; i++) step(0, 0, 1, 0);
        step(1, 1, 1, 0);
        step(0, 0, 1, 0);
        // reset mid-operation
        step(0, 0, 1, 1);
        step(0, 0, 0, 0);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 8) == 0, ($urandom % 5) == 0,
                 ($urandom % 4) != 0, ($urandom % 500) == 0);
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule